// File: doc/BRIEF.md
# Framed Three-Bit Code Detector

This block watches a serial bit stream, one bit per clock, that is cut into back-to-back 3-bit symbols. Symbols never overlap. The first bit sampled after reset is released starts the first symbol, and each symbol begins right after the last bit of the one before. The block raises a single-cycle flag during the last bit of any symbol whose bits, in arrival order, are 0-1-0 or 1-1-0. It also works as a cheap framed pattern recogniser for protocols that carry 3-bit codes at a fixed alignment.

The detector is a Mealy machine with four states held in two flip-flops. Within a symbol the first bit has no effect on the result, so one state covers the position after the first bit. Two states record the second bit. After every third bit the machine returns to its start state. The flag is produced combinationally from the present state and the current input bit, so it is valid in the same cycle as the third bit.

Top module: `frame_code_detector`

## Requirements
- R1: While `rst_n` is low, `hit_out` is 0. A clock edge with `rst_n` low puts the machine in its start state (encoding 2'b00).
- R2: The first bit sampled on the first clock edge with `rst_n` high is bit 1 of a symbol. Bits are then grouped into consecutive 3-bit symbols, and the machine is in the start state whenever a new symbol begins.
- R3: During the third bit of a symbol, `hit_out` is 1 exactly when the second bit was 1 and the third bit is 0 (symbols 010 and 110 in arrival order).
- R4: The value of the first bit of a symbol has no effect on `hit_out` or on the state that follows it. After the first bit the state is always 2'b01.
- R5: `hit_out` is 0 during the first and the second bit of every symbol.
- R6: After the third bit the machine returns to the start state whatever the input. A pattern that crosses a symbol boundary is never reported.
- R7: Pulling `rst_n` low in the middle of a symbol drops the partial symbol. Framing starts again from the first bit after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data, one bit per clock |
| hit_out | output | 1 | High during the third bit of a 010 or 110 symbol |

## Verification
The bound checker keeps its own frame-position counter. On every cycle it checks that the flag is quiet during reset and on the first two bit positions, and that the flag matches the recorded second bit and the current bit on the third position. It also checks that the machine is in the start state at each symbol start and leaves it for the same state whatever the first bit. Some behaviours only show up in the bench's scenarios. These are the swap of first bits with no effect at the output, rejection of patterns that straddle a symbol boundary, and a reset that lands in the middle of a symbol. The bench also runs a long random stream and compares it against a reference model built from a frame counter.

// File: rtl/frame_code_pkg.sv
// Package: shared state type for the framed three-bit code detector.
// Assumes two state bits are enough for the four minimized states.
package frame_code_pkg;

    localparam int STATE_W = 2;

    // Start, after bit 1, after second bit 0, after second bit 1.
    typedef enum logic [STATE_W-1:0] {
        ST_START = 2'b00,
        ST_FIRST = 2'b01,
        ST_MIDZ  = 2'b10,
        ST_MIDO  = 2'b11
    } fc_state_t;

endpackage

// File: rtl/frame_code_next.sv
// Module: next-state and raw flag logic of the detector.
// Purely combinational. Assumes the caller registers next_state
// and qualifies the flag with reset.
module frame_code_next
    import frame_code_pkg::*;
(
    input  fc_state_t cur_state,
    input  logic      bit_in,
    output fc_state_t next_state,
    output logic      hit_raw
);

    // Transition table: bit 1 is ignored, bit 2 chooses the branch, bit 3 ends the symbol.
    always_comb begin
        case (cur_state)
            ST_START: next_state = ST_FIRST;
            ST_FIRST: next_state = bit_in ? ST_MIDO : ST_MIDZ;
            ST_MIDZ:  next_state = ST_START;
            ST_MIDO:  next_state = ST_START;
            default:  next_state = ST_START;
        endcase
    end

    // Mealy flag: the second bit was 1 and the third bit is 0.
    always_comb begin
        hit_raw = (cur_state == ST_MIDO) && !bit_in;
    end

endmodule

// File: rtl/frame_code_state.sv
// Module: state register of the detector.
// Assumes a synchronous, active-low reset that forces the start state.
module frame_code_state
    import frame_code_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fc_state_t next_state,
    output fc_state_t state_q
);

    // Holds the present state; reset restarts framing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= next_state;
        end
    end

endmodule

// File: rtl/frame_code_detector.sv
// Module: top of the framed three-bit code detector.
// Flags symbols 010 and 110 on their third bit. Assumes the stream
// is aligned so that the first bit after reset starts a symbol.
module frame_code_detector
    import frame_code_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit_out
);

    fc_state_t state_q;
    fc_state_t state_d;
    logic      hit_raw;

    frame_code_next next_i (
        .cur_state  (state_q),
        .bit_in     (bit_in),
        .next_state (state_d),
        .hit_raw    (hit_raw)
    );

    frame_code_state state_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (state_d),
        .state_q    (state_q)
    );

    // Output qualify: keep the flag quiet while reset is held.
    always_comb begin
        hit_out = hit_raw && rst_n;
    end

endmodule

// File: rtl/frame_code_detector_chk.sv
// Module: checker bound to the detector. It keeps its own frame
// position and second-bit record, and relates them to the ports and state.
module frame_code_detector_chk
    import frame_code_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_in,
    input logic      hit_out,
    input fc_state_t cur_state
);

    logic [1:0] pos_q;
    logic       second_q;

    // Frame position tracker: 0, 1, 2 and back to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= 2'd0;
        end else begin
            pos_q <= (pos_q == 2'd2) ? 2'd0 : pos_q + 2'd1;
        end
    end

    // Records the second bit of the running symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
        end else if (pos_q == 2'd1) begin
            second_q <= bit_in;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !hit_out); // R1
    AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 2'd0) |-> (cur_state == ST_START)); // R2
    AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 2'd2) |-> (hit_out == (second_q && !bit_in))); // R3
    AST_FIRST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 2'd0) |=> (cur_state == ST_FIRST)); // R4
    AST_NO_EARLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != 2'd2) |-> !hit_out); // R5
    AST_SYMBOL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 2'd2) |=> (cur_state == ST_START)); // R6

endmodule

bind frame_code_detector frame_code_detector_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (bit_in),
    .hit_out   (hit_out),
    .cur_state (state_q)
);

// File: tb/frame_code_detector_tb_top.sv
// Bench: directed corner cases plus a seeded random symbol stream.
module frame_code_detector_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic hit_out;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    frame_code_detector dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .hit_out (hit_out)
    );

    always #4 clk = ~clk;

    // Reference: a symbol is a hit when bit 2 is 1 and bit 3 is 0.
    function automatic logic ref_hit(input logic [2:0] sym);
        return sym[1] && !sym[0];
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: hit_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drives one bit and reset level at the falling edge, samples before the rising edge.
    task automatic drive(input logic rv, input logic b, input logic exp, input string req);
        @(negedge clk);
        rst_n = rv;
        bit_in = b;
        #1;
        check(hit_out, exp, req);
    endtask

    // Sends one symbol; sym[2] goes first.
    task automatic send_sym(input logic [2:0] sym, input string req);
        drive(1'b1, sym[2], 1'b0, req);
        drive(1'b1, sym[1], 1'b0, req);
        drive(1'b1, sym[0], ref_hit(sym), req);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        // R1: flag quiet while reset is held, even on a 1-1-0 pattern.
        drive(1'b0, 1'b1, 1'b0, "R1");
        drive(1'b0, 1'b1, 1'b0, "R1");
        drive(1'b0, 1'b0, 1'b0, "R1");
        drive(1'b0, 1'b0, 1'b0, "R1");
        // R2/R3: every code in order right after reset release.
        for (int c = 0; c < 8; c++) begin
            send_sym(3'(c), "R3");
        end
        // R4: first bit swapped, same result.
        send_sym(3'b010, "R4");
        send_sym(3'b110, "R4");
        send_sym(3'b011, "R4");
        send_sym(3'b111, "R4");
        // R6: 101 then 000 holds 0-1-0 across the boundary; no hit.
        send_sym(3'b101, "R6");
        send_sym(3'b000, "R6");
        send_sym(3'b001, "R6");
        send_sym(3'b011, "R6");
        // R7: reset after two bits of a symbol, then a fresh 010.
        drive(1'b1, 1'b0, 1'b0, "R7");
        drive(1'b1, 1'b1, 1'b0, "R7");
        drive(1'b0, 1'b0, 1'b0, "R7");
        send_sym(3'b010, "R7");
        drive(1'b1, 1'b1, 1'b0, "R7");
        drive(1'b0, 1'b1, 1'b0, "R7");
        send_sym(3'b110, "R7");
        // R5 and R3: seeded random stream.
        for (int s = 0; s < 400; s++) begin
            send_sym(3'($urandom_range(0, 7)), "R5");
        end
        done = 1'b1;
    end

    // Ends the run, counting an expired watchdog as a failure.
    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule